// File: doc/BRIEF.md
# External Data Cycle Stretch Timer

This block sequences one external data-memory read or write for a core that runs one system clock per machine cycle. A request carries a direction flag, a 16-bit address and a write byte. When the request is accepted, the block captures it together with a 3-bit stretch code. It then drives an address latch enable, a multiplexed low address/data byte, a separate high address byte, and one active-low strobe for the read or the write. When the access ends it returns a one-cycle response that carries the byte read from the bus.

The request side is a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While a cycle runs, `req_ready` stays low and any `req_valid` is ignored, so the requester holds back until ready returns. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse, and the requester must take `rsp_data` in that cycle. The stretch code is a plain control input, usually driven from a software-writable register. It may change at any time, but it only affects accesses accepted after the change.

The stretch code selects how many extra clocks the strobe lasts. The mapping is non-linear. The upper half of the codes also adds one clock of address setup before the strobe and one clock of hold after it.

Top module: `xst_timer`

## Requirements
- R1: While `rst` is high at a clock edge, and in every idle cycle afterwards, the outputs are `rd_n`=1, `wr_n`=1, `ale`=0, `busy`=0 and `req_ready`=1. After reset, `ad_oe`=0 and `rsp_valid`=0.
- R2: Counting from the first cycle after acceptance, `busy` stays high for exactly 4+S cycles when the stretch code is below 4, and for 6+S cycles when the code is 4 or more. The stretch count S is 0,1,2,3,7,8,9,10 for codes 0 to 7, so S equals the code for codes 0–3 and the code plus 3 for codes 4–7.
- R3: `ale` is high in the first busy cycle only. The low address byte is driven with `ad_oe`=1 in that cycle and in every cycle before the strobe, so it is stable at the falling edge of `ale`.
- R4: `addr_hi` carries address bits 15:8 in every busy cycle.
- R5: The strobe is low for exactly 1+S consecutive cycles. A read drives only `rd_n` low and a write drives only `wr_n` low; the two are never low together.
- R6: The strobe falls 2 cycles after the `ale` cycle for codes 0–3 and 3 cycles after it for codes 4–7. After the strobe rises, `busy` stays high for 1 more cycle for codes 0–3 and 2 more cycles for codes 4–7.
- R7: A read returns the value `ad_in` held during the last strobe-low cycle. `rsp_data` takes that value at the clock edge where `rd_n` rises.
- R8: During a write, `ad_out` carries the write byte with `ad_oe`=1 from the first strobe cycle to the end of the access, which is at least one cycle after `wr_n` rises. During a read, `ad_oe` is 0 from the first strobe cycle to the end of the access.
- R9: `req_ready` is low whenever `busy` is high. A `req_valid` raised while busy starts no access and leaves the running access unchanged.
- R10: The stretch code is sampled only at acceptance. Changing it during an access does not change that access's timing.
- R11: `rsp_valid` is high for exactly one cycle, the first cycle after `busy` falls, once per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-memory address |
| req_wdata | input | 8 | Byte to write |
| stretch_code | input | 3 | Stretch selection, sampled at acceptance |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Multiplexed low address / write data |
| ad_oe | output | 1 | Output enable for the multiplexed byte |
| ad_in | input | 8 | Multiplexed byte read from the bus |
| addr_hi | output | 8 | High address byte |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | One-cycle end-of-access pulse |
| rsp_data | output | 8 | Byte captured by the last read |

## Verification
The bench uses the default widths: a 16-bit address, an 8-bit data byte and a 3-bit stretch code. With only eight codes, every code is run as both a read and a write, so every stretch length is covered, including the jump from 3 to 7 and the added setup and hold. For each access the bench computes the cycle of every edge from the code and checks each output in each cycle. On reads it changes `ad_in` everywhere except the last strobe cycle, which pins down the capture point. Other accesses raise a second request and flip the stretch code in the middle of a cycle, and cover the all-ones and all-zeros address boundaries.

// File: rtl/xst_pkg.sv
package xst_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ALE   = 3'd1,
    PH_ADR   = 3'd2,
    PH_SETUP = 3'd3,
    PH_STB   = 3'd4,
    PH_HOLD  = 3'd5,
    PH_REC   = 3'd6
  } xst_phase_e;

endpackage

// File: rtl/xst_len_map.sv
module xst_len_map #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  extra,
  output logic              wide
);
  localparam int HALF = 1 << (CODE_W - 1);

  // Upper half of the code range jumps by HALF-1 and widens setup/hold.
  always_comb begin
    wide = code[CODE_W-1];
    if (wide) extra = CNT_W'(code) + CNT_W'(HALF - 1);
    else      extra = CNT_W'(code);
  end
endmodule

// File: rtl/xst_seq.sv
module xst_seq
  import xst_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] extra_in,
  input  logic             wide_in,
  output xst_phase_e       phase,
  output logic             last_stb,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             wide_q;

  assign last_stb = (phase == PH_STB) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt_q  <= '0;
      wide_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= (phase == PH_REC);
      unique case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_ALE;
          cnt_q  <= extra_in;
          wide_q <= wide_in;
        end
        PH_ALE:   phase <= PH_ADR;
        PH_ADR:   phase <= wide_q ? PH_SETUP : PH_STB;
        PH_SETUP: phase <= PH_STB;
        PH_STB: begin
          if (cnt_q == '0) phase <= wide_q ? PH_HOLD : PH_REC;
          else             cnt_q <= cnt_q - 1'b1;
        end
        PH_HOLD:  phase <= PH_REC;
        PH_REC:   phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xst_bus.sv
module xst_bus
  import xst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  xst_phase_e          phase,
  input  logic                last_stb,
  input  logic [DATA_W-1:0]   ad_in,
  output logic                ale,
  output logic                rd_n,
  output logic                wr_n,
  output logic [DATA_W-1:0]   ad_out,
  output logic                ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]   rdata
);
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              addr_ph;
  logic              data_ph;
  logic              strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      if (accept) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      // Sampled on the edge that ends the strobe, i.e. where rd_n rises.
      if (last_stb && !wr_q) rdata <= ad_in;
    end
  end

  always_comb begin
    addr_ph = (phase == PH_ALE) || (phase == PH_ADR) || (phase == PH_SETUP);
    data_ph = (phase == PH_STB) || (phase == PH_HOLD) || (phase == PH_REC);
    strobe  = (phase == PH_STB);
    ale     = (phase == PH_ALE);
    rd_n    = !(strobe && !wr_q);
    wr_n    = !(strobe && wr_q);
    ad_oe   = addr_ph || (data_ph && wr_q);
    if (addr_ph)               ad_out = addr_q[DATA_W-1:0];
    else if (data_ph && wr_q)  ad_out = wdata_q;
    else                       ad_out = '0;
  end

  assign addr_hi = addr_q[ADDR_W-1:DATA_W];
endmodule

// File: rtl/xst_timer.sv
module xst_timer
  import xst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CODE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [CODE_W-1:0]        stretch_code,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     busy,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data
);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int MAX_S = ((1 << CODE_W) - 1) + ((1 << (CODE_W - 1)) - 1);
  localparam int CNT_W = $clog2(MAX_S + 1);

  xst_phase_e       phase;
  logic             last_stb;
  logic             accept;
  logic [CNT_W-1:0] extra;
  logic             wide;

  assign req_ready = (phase == PH_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;

  xst_len_map #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_map (
    .code  (stretch_code),
    .extra (extra),
    .wide  (wide)
  );

  xst_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .extra_in (extra),
    .wide_in  (wide),
    .phase    (phase),
    .last_stb (last_stb),
    .done     (rsp_valid)
  );

  xst_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .phase     (phase),
    .last_stb  (last_stb),
    .ad_in     (ad_in),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .addr_hi   (addr_hi),
    .rdata     (rsp_data)
  );
endmodule

// File: rtl/xst_checker.sv
module xst_checker #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ad_oe,
  input logic [HI_W-1:0] addr_hi,
  input logic            busy,
  input logic            req_ready,
  input logic            rsp_valid
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (rd_n && wr_n && !ale)); // R1
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n || ale) |-> !req_ready); // R9
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale); // R3
  AST_ALE_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ale); // R3
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !ale) |-> $stable(addr_hi)); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R5
  AST_SETUP_GAP: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n) || $fell(wr_n)) |-> !$past(ale)); // R6
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe); // R8
  AST_RD_FLOATS: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R11
  AST_RSP_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rsp_valid); // R11
endmodule

bind xst_timer xst_checker #(.HI_W(HI_W)) u_xst_checker (
  .clk       (clk),
  .rst       (rst),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .addr_hi   (addr_hi),
  .busy      (busy),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/test_xst_timer.sv
module test_xst_timer;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic [2:0]  stretch_code;
  logic        ale, rd_n, wr_n, ad_oe, busy, rsp_valid;
  logic [7:0]  ad_out, ad_in, addr_hi, rsp_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  xst_timer i_xst_timer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .stretch_code(stretch_code), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic [2:0] code, input bit wr, input logic [15:0] addr,
                           input logic [7:0] wdata, input logic [7:0] rdval, input bit disturb);
    int s, wide, s0, send, total;
    s     = (code < 4) ? int'(code) : int'(code) + 3;
    wide  = (code >= 4) ? 1 : 0;
    s0    = 2 + wide;
    send  = s0 + s;
    total = 4 + s + 2 * wide;
    @(negedge clk);
    chk("R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wdata;
    stretch_code = code;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < total; i++) begin
      bit low;
      ad_in = (i == send) ? rdval : ~rdval;
      if (disturb && i == 1) begin
        // R9 R10: a second request and a new stretch code mid-access
        req_valid = 1'b1; req_write = ~wr; req_addr = ~addr; req_wdata = ~wdata;
        stretch_code = code ^ 3'b111;
      end
      if (disturb && i == 2) req_valid = 1'b0;
      low = (i >= s0) && (i <= send);
      chk(disturb ? "R10 busy length" : "R2 busy length", busy, 1);
      chk("R9 ready low", req_ready, 0);
      chk("R3 ale", ale, (i == 0) ? 1 : 0);
      chk("R4 addr_hi", addr_hi, addr[15:8]);
      chk("R5 R6 rd_n", rd_n, (low && !wr) ? 0 : 1);
      chk("R5 R6 wr_n", wr_n, (low && wr) ? 0 : 1);
      if (i < s0) begin
        chk("R3 ad_oe addr", ad_oe, 1);
        chk("R3 ad_out addr", ad_out, addr[7:0]);
      end else if (wr) begin
        chk("R8 ad_oe write", ad_oe, 1);
        chk("R8 ad_out write", ad_out, wdata);
      end else begin
        chk("R8 ad_oe read", ad_oe, 0);
      end
      chk("R11 no early rsp", rsp_valid, 0);
      @(negedge clk);
    end
    chk(disturb ? "R10 busy end" : "R2 busy end", busy, 0);
    chk("R11 rsp pulse", rsp_valid, 1);
    if (!wr) chk("R7 read data", rsp_data, rdval);
    stretch_code = code;
    @(negedge clk);
    chk("R11 rsp single", rsp_valid, 0);
    chk(disturb ? "R9 ignored start" : "R1 idle after", busy, 0);
    chk("R1 idle strobes", {rd_n, wr_n, ale}, 3'b110);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; stretch_code = '0; ad_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 rd_n reset", rd_n, 1);
    chk("R1 wr_n reset", wr_n, 1);
    chk("R1 ale reset", ale, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 ready reset", req_ready, 1);
    chk("R1 ad_oe reset", ad_oe, 0);
    chk("R1 rsp reset", rsp_valid, 0);
    rst = 1'b0;

    for (int c = 0; c < 8; c++) begin
      for (int w = 0; w < 2; w++) begin
        logic [15:0] a;
        a = 16'h1234 ^ (16'(c) * 16'h1111) ^ (16'(w) << 7);
        do_access(3'(c), w[0], a, 8'h5A + 8'(c), 8'hC3 ^ 8'(c << 2), 1'b0);
      end
    end
    do_access(3'd2, 1'b0, 16'hFFFF, 8'h00, 8'hA5, 1'b1);
    do_access(3'd6, 1'b1, 16'h0000, 8'hFF, 8'h3C, 1'b1);
    do_access(3'd7, 1'b0, 16'h8001, 8'h11, 8'h7E, 1'b1);
    do_access(3'd0, 1'b1, 16'h7FFE, 8'h81, 8'h00, 1'b1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule